// File: doc/BRIEF.md
# Tuning Reference Divider and Phase Comparator

This block is the digital core of a frequency synthesiser for a radio tuner. A crystal enable pulse arrives once per period of a 75 kHz crystal, and a selectable divider turns it into a tuning reference of 1, 3, 3.125, 5, 6.25, 12.5 or 25 kHz. A second pulse stream carries the local-oscillator edges. On the FM band these edges first pass through a fixed divide-by-16 prescale step, which models a dual-modulus front stage. On the AM band they go straight to the programmable N counter.

A three-state comparator sets the charge-pump drive from the order in which reference and divided events arrive. The pump drives high when the divided local frequency runs ahead of the reference. It drives low when the divided frequency lags. When the two events pair up, and whenever the loop is held, the pump goes high-impedance. A cycle slip, meaning a second event of one kind before its partner arrives, sets a sticky unlock flag that only an explicit clear strobe removes.

Every input is a plain control pin sampled on `clk`. The block has no streamed data path, so no valid/ready handshake and no back-pressure apply. `xtal_tick` and `lo_pulse` are single-cycle enables in the `clk` domain.

Top module: `pll_ref_phase`

## Requirements
- R1: `ref_sel` picks the reference divide ratio as 0→75, 1→25, 2→24, 3→15, 4→12, 5→6, 6→3, 7→3. One reference event occurs on every ratio-th `xtal_tick`, counted from a restart.
- R2: With `band_fm`=1, only every 16th `lo_pulse` advances the N counter. With `band_fm`=0, every `lo_pulse` advances it.
- R3: The N counter produces one divided event per N advancing pulses. An `n_value` of 0 is treated as 1.
- R4: A new `n_value` is loaded only at a terminal count. After a reset or a restart, the first advancing pulse is itself a terminal count, and it loads `n_value`.
- R5: If a divided event arrives with no reference event pending, `pump_drv` becomes 2'b01 (drive high) from the next cycle. It stays there until a reference event arrives.
- R6: If a reference event arrives with no divided event pending, `pump_drv` becomes 2'b10 (drive low). An event that meets its pending partner, or two events in the same cycle, return `pump_drv` to 2'b00 (high-impedance). 2'b11 never appears.
- R7: While `halt` or `pll_stop` is high, `pump_drv` is 2'b00. Pending events are discarded and both dividers return to their start state.
- R8: After reset, `pump_drv` is 2'b00, `unlock` is 0, and both dividers are at their start state.
- R9: `unlock` sets in the cycle after a second event of one kind arrives while an event of that kind is already pending. It then stays set.
- R10: A high `unlock_clr` clears `unlock` on the next edge. If a slip occurs in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle enable per crystal period |
| lo_pulse | input | 1 | One-cycle pulse per local-oscillator edge |
| ref_sel | input | 3 | Reference ratio code |
| n_value | input | NW | Programmable divide value N |
| band_fm | input | 1 | 1: prescale by 16 before the N counter |
| halt | input | 1 | Halt mode: loop held |
| pll_stop | input | 1 | Loop stop: loop held |
| unlock_clr | input | 1 | Clear strobe for the unlock flag |
| pump_drv | output | 2 | 00 high-Z, 01 drive high, 10 drive low |
| unlock | output | 1 | Sticky slip flag |

## Verification
The assertions assume that `xtal_tick` and `lo_pulse` are clean single-cycle enables in the `clk` domain. They also assume that `ref_sel` and `n_value` are static levels, not pulses. The stimulus drives every input only at the falling clock edge, so each value is held for one full cycle. A one-cycle `pll_stop` pulse restarts the loop from a known state before each directed sequence. A reference model tracks both counters and the pending flags cycle by cycle, and this covers the checks on the N reload timing and the slip priority.

// File: rtl/pll_refpd_pkg.sv
package pll_refpd_pkg;

  localparam int RATIO_W = 7;

  typedef enum logic [1:0] {
    PUMP_Z  = 2'b00,
    PUMP_HI = 2'b01,
    PUMP_LO = 2'b10
  } pump_e;

  function automatic logic [RATIO_W-1:0] ref_ratio(input logic [2:0] code);
    case (code)
      3'd0:    ref_ratio = 7'd75;
      3'd1:    ref_ratio = 7'd25;
      3'd2:    ref_ratio = 7'd24;
      3'd3:    ref_ratio = 7'd15;
      3'd4:    ref_ratio = 7'd12;
      3'd5:    ref_ratio = 7'd6;
      default: ref_ratio = 7'd3;
    endcase
  endfunction

endpackage

// File: rtl/pll_ref_divider.sv
module pll_ref_divider
  import pll_refpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic [2:0] sel,
  output logic       ref_edge
);
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] lim;
  logic               term;

  assign lim      = ref_ratio(sel) - RATIO_W'(1);
  assign term     = (cnt >= lim);
  assign ref_edge = run & tick & term;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= term ? '0 : cnt + RATIO_W'(1);
  end

  assert_ref_needs_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |-> tick);

endmodule

// File: rtl/pll_lo_divider.sv
module pll_lo_divider #(
  parameter int NW       = 12,
  parameter int PRESCALE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          lo_pulse,
  input  logic          band_fm,
  input  logic [NW-1:0] n_value,
  output logic          div_edge
);
  logic          pre_pulse;
  logic [NW-1:0] n_cnt;
  logic [NW-1:0] n_act;
  logic [NW-1:0] n_eff;
  logic          term;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre;
      logic          pre_wrap;
      assign pre_wrap  = (pre == PW'(PRESCALE - 1));
      assign pre_pulse = band_fm ? (lo_pulse & pre_wrap) : lo_pulse;
      always_ff @(posedge clk) begin
        if (!rst_n || !run)        pre <= '0;
        else if (band_fm && lo_pulse) pre <= pre_wrap ? '0 : pre + PW'(1);
      end
    end else begin : g_nopre
      assign pre_pulse = lo_pulse;
    end
  endgenerate

  assign n_eff    = (n_value == '0) ? NW'(1) : n_value;
  assign term     = (n_cnt >= n_act - NW'(1));
  assign div_edge = run & pre_pulse & term;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      n_cnt <= '0;
      n_act <= NW'(1);
    end else if (pre_pulse) begin
      if (term) begin
        n_cnt <= '0;
        n_act <= n_eff;
      end else begin
        n_cnt <= n_cnt + NW'(1);
      end
    end
  end

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    n_cnt < n_act);
  assert_div_needs_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_edge |-> lo_pulse);

endmodule

// File: rtl/pll_phase_cmp.sv
module pll_phase_cmp
  import pll_refpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ref_edge,
  input  logic       div_edge,
  input  logic       unlock_clr,
  output logic [1:0] pump_drv,
  output logic       unlock
);
  logic  up_q, dn_q;
  logic  nxt_up, nxt_dn, slip;
  pump_e pump;

  assign nxt_up = up_q | div_edge;
  assign nxt_dn = dn_q | ref_edge;
  assign slip   = (up_q & div_edge) | (dn_q & ref_edge);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (nxt_up && nxt_dn) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= nxt_up;
      dn_q <= nxt_dn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           unlock <= 1'b0;
    else if (run && slip) unlock <= 1'b1;
    else if (unlock_clr)  unlock <= 1'b0;
  end

  always_comb begin
    if (!run)      pump = PUMP_Z;
    else if (up_q) pump = PUMP_HI;
    else if (dn_q) pump = PUMP_LO;
    else           pump = PUMP_Z;
  end
  assign pump_drv = pump;

  assert_no_dual_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));
  assert_pump_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pump_drv != 2'b11);
  assert_unlock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && !unlock_clr) |=> unlock);
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!up_q && !dn_q));

endmodule

// File: rtl/pll_ref_phase.sv
module pll_ref_phase
  import pll_refpd_pkg::*;
#(
  parameter int NW       = 12,
  parameter int PRESCALE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_tick,
  input  logic          lo_pulse,
  input  logic [2:0]    ref_sel,
  input  logic [NW-1:0] n_value,
  input  logic          band_fm,
  input  logic          halt,
  input  logic          pll_stop,
  input  logic          unlock_clr,
  output logic [1:0]    pump_drv,
  output logic          unlock
);
  logic run, ref_edge, div_edge;

  assign run = !(halt || pll_stop);

  pll_ref_divider u_ref (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(xtal_tick),
    .sel(ref_sel), .ref_edge(ref_edge)
  );

  pll_lo_divider #(.NW(NW), .PRESCALE(PRESCALE)) u_lo (
    .clk(clk), .rst_n(rst_n), .run(run), .lo_pulse(lo_pulse),
    .band_fm(band_fm), .n_value(n_value), .div_edge(div_edge)
  );

  pll_phase_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_edge(ref_edge),
    .div_edge(div_edge), .unlock_clr(unlock_clr),
    .pump_drv(pump_drv), .unlock(unlock)
  );

  assert_held_is_z_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt || pll_stop) |-> (pump_drv == 2'b00));

endmodule

// File: tb/tb_pll_ref_phase.sv
module tb_pll_ref_phase;
  localparam int NW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xtal_tick, lo_pulse, band_fm, halt, pll_stop, unlock_clr;
  logic [2:0]    ref_sel;
  logic [NW-1:0] n_value;
  logic [1:0]    pump_drv;
  logic          unlock;

  always #2.5 clk = ~clk;

  pll_ref_phase #(.NW(NW), .PRESCALE(16)) dut (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .lo_pulse(lo_pulse),
    .ref_sel(ref_sel), .n_value(n_value), .band_fm(band_fm), .halt(halt),
    .pll_stop(pll_stop), .unlock_clr(unlock_clr),
    .pump_drv(pump_drv), .unlock(unlock)
  );

  typedef struct {
    logic [1:0] pump;
    logic       unl;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  // bench-side state of the loop, derived from the requirements
  int m_ref, m_pre, m_n, m_nact;
  bit m_up, m_dn, m_unl;
  logic [2:0]    b_sel = 3'd6;
  logic [NW-1:0] b_n   = 12'd4;
  bit b_fm = 0, b_halt = 0, b_stop = 0;

  function automatic int ratio_of(input logic [2:0] s);
    int t[8] = '{75, 25, 24, 15, 12, 6, 3, 3};
    return t[s];
  endfunction

  task automatic model_reset();
    m_ref = 0; m_pre = 0; m_n = 0; m_nact = 1; m_up = 0; m_dn = 0;
  endtask

  task automatic step(input bit tk, input bit lo, input bit clr, input string tag);
    exp_t e;
    bit re, pp, de, nu, nd, sl;
    @(negedge clk);
    xtal_tick = tk; lo_pulse = lo; unlock_clr = clr;
    ref_sel = b_sel; n_value = b_n; band_fm = b_fm; halt = b_halt; pll_stop = b_stop;
    if (b_halt || b_stop) begin
      model_reset();
      if (clr) m_unl = 0;
      e.pump = 2'b00;
    end else begin
      re = tk && (m_ref >= ratio_of(b_sel) - 1);
      if (tk) m_ref = re ? 0 : m_ref + 1;
      pp = b_fm ? (lo && m_pre == 15) : lo;
      if (b_fm && lo) m_pre = (m_pre == 15) ? 0 : m_pre + 1;
      de = pp && (m_n >= m_nact - 1);
      if (pp) begin
        if (de) begin m_n = 0; m_nact = (b_n == 0) ? 1 : int'(b_n); end
        else m_n = m_n + 1;
      end
      nu = m_up | de; nd = m_dn | re;
      sl = (m_up & de) | (m_dn & re);
      if (nu && nd) begin m_up = 0; m_dn = 0; end
      else begin m_up = nu; m_dn = nd; end
      if (sl) m_unl = 1; else if (clr) m_unl = 0;
      e.pump = m_up ? 2'b01 : (m_dn ? 2'b10 : 2'b00);
    end
    e.unl = m_unl;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic restart(input string tag);
    b_stop = 1; step(0, 0, 0, tag); b_stop = 0;
  endtask

  // monitor: compares each cycle's outputs against the queued expectation
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (pump_drv !== e.pump || unlock !== e.unl) begin
          fails++;
          $display("FAIL %s: pump=%b unlock=%b expected pump=%b unlock=%b",
                   e.tag, pump_drv, unlock, e.pump, e.unl);
        end
      end
    end
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    rst_n = 0; xtal_tick = 0; lo_pulse = 0; unlock_clr = 0;
    ref_sel = 3'd6; n_value = 12'd4; band_fm = 0; halt = 0; pll_stop = 0;
    m_unl = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    checks++;
    if (pump_drv !== 2'b00 || unlock !== 1'b0) begin // R8
      fails++;
      $display("FAIL R8: pump=%b unlock=%b expected pump=00 unlock=0", pump_drv, unlock);
    end

    // R1: every ratio code, ticks only, drive-low after the ratio-th tick
    for (int s = 0; s < 8; s++) begin
      b_sel = 3'(s);
      restart("R7");
      for (int k = 0; k < ratio_of(3'(s)); k++) step(1, 0, 0, "R1");
      step(0, 0, 0, "R6");
    end

    // R3/R5/R6: AM band, N=4, reference ratio 3
    b_sel = 3'd6; b_fm = 0; b_n = 12'd4;
    restart("R8");
    step(0, 1, 0, "R4");               // first pulse is terminal, drive high
    for (int k = 0; k < 3; k++) step(1, 0, 0, "R5");
    for (int k = 0; k < 24; k++) step(k % 3 == 0, k % 2 == 0, 0, "R3");
    b_n = 12'd0;
    for (int k = 0; k < 12; k++) step(k % 4 == 0, 1, 0, "R3");

    // R4: change N mid-count
    b_n = 12'd5;
    restart("R7");
    step(0, 1, 0, "R4");
    step(1, 0, 0, "R4"); step(1, 0, 0, "R4"); step(1, 0, 0, "R4");
    step(0, 1, 0, "R4"); step(0, 1, 0, "R4");
    b_n = 12'd2;
    for (int k = 0; k < 6; k++) step(0, 1, 0, "R4");
    step(0, 0, 1, "R10");

    // R2: FM prescale by 16
    b_fm = 1; b_n = 12'd1;
    restart("R7");
    for (int k = 0; k < 20; k++) step(0, 1, 0, "R2");
    for (int k = 0; k < 40; k++) step(k % 2 == 0, 1, 0, "R2");
    b_fm = 0;

    // R9/R10: slips, clear, set-over-clear priority
    restart("R7");
    step(0, 0, 1, "R10");
    for (int k = 0; k < 6; k++) step(1, 0, 0, "R9");
    step(0, 0, 0, "R9");
    step(0, 0, 1, "R10");
    step(1, 0, 0, "R10"); step(1, 0, 0, "R10"); step(1, 0, 1, "R10");
    step(0, 0, 0, "R10");

    // R7: halt with a pending divided event
    b_n = 12'd1;
    restart("R7");
    step(0, 1, 0, "R5");
    b_halt = 1;
    step(1, 1, 0, "R7"); step(1, 1, 0, "R7");
    b_halt = 0;
    step(0, 0, 0, "R7");
    step(1, 0, 0, "R7"); step(1, 0, 0, "R7"); step(1, 0, 0, "R6");

    // mixed pattern
    lf = 8'h5a;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (k % 100 == 0) begin b_n = NW'(k / 100 + 1); b_fm = (k == 300); end
      step(lf[0], lf[1] & lf[2], lf[3] & lf[4] & lf[5], "R6");
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule